// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block turns a graphics-aperture bus address into a physical address. The upper part of the address, taken relative to a programmable aperture base, picks one of 64 on-chip directory entries. Each present entry points to a 4 KB second-level page held in system memory. That page holds 1024 four-byte entries, so one directory entry spans 4 MB of aperture. The middle address bits pick the second-level entry. The block fetches that entry through a single-beat memory read port. It then joins the stored page frame with the low twelve bits of the request.

Software programs the block through one configuration write port. Four targets share it: a packed directory-load word, the aperture base, an aperture-size code and a control word. A small fully associative cache holds recent translations. Software empties it by writing control bit 7 low and then high. Only one translation is in flight at a time. A request that falls outside the configured aperture, that hits an absent directory entry, or that reads an unmapped second-level entry completes with a fault flag and a zero address.

Top module: `aper_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_rd_valid` are 0. The cache is empty and no directory entry is present.
- R2: A configuration write with `cfg_sel`=0 loads one directory entry. Word bits 5:0 select the entry, bit 8 is the present flag, and bits 31:12 hold the second-level page frame. Bits 11:9 and 7:6 are ignored. A word with bit 8 clear makes that entry absent.
- R3: The directory index is request bits 31:22 minus bits 31:22 of the aperture base, which is written with `cfg_sel`=1. On a miss, `mem_rd_addr` is the entry's page frame in bits 31:12, request bits 21:12 in bits 11:2, and zero in bits 1:0.
- R4: On a miss, `mem_rd_valid` pulses for exactly one cycle, one cycle after the request is accepted. The response comes one cycle after `mem_rsp_valid`. When `mem_rsp_data` bit 0 is set, `rsp_addr` is `mem_rsp_data[31:12]` joined with request bits 11:0.
- R5: A fetched second-level entry with bit 0 clear gives `rsp_fault`=1 and `rsp_addr`=0. Such an entry is not cached.
- R6: The size code is written with `cfg_sel`=2. The number of usable directory entries is 64 shifted right by the count of set bits in code bits 5:3. So code 0 gives 256 MB, 32 gives 128 MB, 48 gives 64 MB and 56 gives 32 MB. A relative index at or beyond that limit faults one cycle after acceptance, with no memory read. An address below the base wraps and so also faults.
- R7: A request whose directory entry is absent faults one cycle after acceptance, with no memory read.
- R8: A request for a cached page responds one cycle after acceptance, with no memory read.
- R9: The cache holds 4 pages with round-robin replacement. Once 5 distinct pages have been fetched after a flush, the first one misses again.
- R10: A control write (`cfg_sel`=3) that takes bit 7 from 0 to 1 empties the cache. A control write that leaves bit 7 at 1 has no effect on the cache.
- R11: A flush written while a fetch is outstanding takes effect when that fetch completes. The fetched translation is still returned but is not cached.
- R12: `req_ready` is low from the acceptance of a missing request until its response. Only one translation is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 directory, 1 base, 2 size, 3 control |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Aperture bus address |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_addr | output | 32 | Physical address, zero on fault |
| mem_rd_valid | output | 1 | Second-level entry read request |
| mem_rd_addr | output | 32 | Byte address of the second-level entry |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Second-level entry value |

## Verification
Faults and cache hits are due exactly one cycle after the accepting edge. On a miss, the memory read appears one cycle after acceptance and the response one cycle after the read data. The bench drives inputs on falling edges and samples one falling edge after each relevant rising edge. Before each request it predicts which of these paths will be taken, using its own model of the directory, the size limit and a round-robin cache. It then checks the read strobe, the read address and the response exactly at those points. It also checks that `req_ready` stays low on every cycle of a variable-latency fetch.

// File: rtl/aper_xlate_pkg.sv
package aper_xlate_pkg;

    localparam int ADDR_W  = 32;
    localparam int PAGE_SH = 12;
    localparam int FRAME_W = ADDR_W - PAGE_SH;
    localparam int SPAN_SH = 22;
    localparam int REL_W   = ADDR_W - SPAN_SH;

    localparam logic [1:0] SEL_DIR  = 2'd0;
    localparam logic [1:0] SEL_BASE = 2'd1;
    localparam logic [1:0] SEL_SIZE = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    typedef enum logic {ST_IDLE, ST_WAIT} xl_state_e;

    typedef struct packed {
        xl_state_e           state;
        logic [REL_W-1:0]    base;
        logic [7:0]          size_code;
        logic                ctl_on;
        logic                flush_pend;
        logic [ADDR_W-1:0]   held_addr;
        logic                mem_rd_valid;
        logic [ADDR_W-1:0]   mem_rd_addr;
        logic                rsp_valid;
        logic                rsp_fault;
        logic [ADDR_W-1:0]   rsp_addr;
    } xl_regs_t;

endpackage

// File: rtl/xl_dir.sv
module xl_dir #(
    parameter int ENTRIES = 64,
    parameter int FRAME_W = 20,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [31:0]        wr_word,
    input  logic [IW-1:0]      rd_idx,
    output logic               rd_present,
    output logic [FRAME_W-1:0] rd_frame
);

    typedef struct packed {
        logic [ENTRIES-1:0]              present;
        logic [ENTRIES-1:0][FRAME_W-1:0] frame;
    } dir_t;

    dir_t dir_d, dir_q;

    always_comb begin
        dir_d = dir_q;
        if (wr_en) begin
            dir_d.present[wr_word[IW-1:0]] = wr_word[8];
            dir_d.frame[wr_word[IW-1:0]]   = wr_word[31:32-FRAME_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else begin
            dir_q <= dir_d;
        end
    end

    assign rd_present = dir_q.present[rd_idx];
    assign rd_frame   = dir_q.frame[rd_idx];

    // R2
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (dir_q.present[$past(wr_word[IW-1:0])] == $past(wr_word[8])));

endmodule

// File: rtl/xl_tcache.sv
module xl_tcache #(
    parameter int WAYS   = 4,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 20,
    localparam int PW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              ins_en,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic [DATA_W-1:0] ins_data,
    input  logic              flush
);

    typedef struct packed {
        logic [WAYS-1:0]             valid;
        logic [WAYS-1:0][TAG_W-1:0]  tag;
        logic [WAYS-1:0][DATA_W-1:0] data;
        logic [PW-1:0]               ptr;
    } cache_t;

    cache_t c_d, c_q;
    logic [WAYS-1:0] hit_vec;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign hit_vec[g] = c_q.valid[g] && (c_q.tag[g] == lk_tag);
    end

    always_comb begin
        lk_data = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i]) lk_data = lk_data | c_q.data[i];
        end
    end
    assign lk_hit = |hit_vec;

    always_comb begin
        c_d = c_q;
        if (flush) begin
            c_d.valid = '0;
            c_d.ptr   = '0;
        end else if (ins_en) begin
            c_d.valid[c_q.ptr] = 1'b1;
            c_d.tag[c_q.ptr]   = ins_tag;
            c_d.data[c_q.ptr]  = ins_data;
            c_d.ptr = (c_q.ptr == PW'(WAYS - 1)) ? '0 : c_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    // R9
    hit_one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

endmodule

// File: rtl/aper_xlate.sv
module aper_xlate
    import aper_xlate_pkg::*;
#(
    parameter int DIR_ENTRIES = 64,
    parameter int CACHE_WAYS  = 4,
    localparam int DIR_IW = $clog2(DIR_ENTRIES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    output logic        req_ready,
    output logic        rsp_valid,
    output logic        rsp_fault,
    output logic [31:0] rsp_addr,
    output logic        mem_rd_valid,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data
);

    xl_regs_t r_d, r_q;

    logic [REL_W-1:0]   rel_idx;
    logic [DIR_IW:0]    dir_limit;
    logic               in_range;
    logic               dir_present;
    logic [FRAME_W-1:0] dir_frame;
    logic               hit;
    logic [FRAME_W-1:0] hit_frame;
    logic               flush_req;
    logic               flush_now;
    logic               ins_en;

    assign rel_idx   = req_addr[ADDR_W-1:SPAN_SH] - r_q.base;
    assign dir_limit = (DIR_IW+1)'(DIR_ENTRIES) >> $countones(r_q.size_code[5:3]);
    assign in_range  = 32'(rel_idx) < 32'(dir_limit);
    assign flush_req = cfg_we && (cfg_sel == SEL_CTRL) && cfg_wdata[7] && !r_q.ctl_on;

    xl_dir #(.ENTRIES(DIR_ENTRIES), .FRAME_W(FRAME_W)) u_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we && (cfg_sel == SEL_DIR)),
        .wr_word    (cfg_wdata),
        .rd_idx     (rel_idx[DIR_IW-1:0]),
        .rd_present (dir_present),
        .rd_frame   (dir_frame)
    );

    xl_tcache #(.WAYS(CACHE_WAYS), .TAG_W(FRAME_W), .DATA_W(FRAME_W)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_tag   (req_addr[ADDR_W-1:PAGE_SH]),
        .lk_hit   (hit),
        .lk_data  (hit_frame),
        .ins_en   (ins_en),
        .ins_tag  (r_q.held_addr[ADDR_W-1:PAGE_SH]),
        .ins_data (mem_rsp_data[ADDR_W-1:PAGE_SH]),
        .flush    (flush_now)
    );

    always_comb begin
        r_d = r_q;
        r_d.mem_rd_valid = 1'b0;
        r_d.rsp_valid    = 1'b0;
        flush_now = 1'b0;
        ins_en    = 1'b0;

        if (cfg_we) begin
            case (cfg_sel)
                SEL_BASE: r_d.base      = cfg_wdata[ADDR_W-1:SPAN_SH];
                SEL_SIZE: r_d.size_code = cfg_wdata[7:0];
                SEL_CTRL: r_d.ctl_on    = cfg_wdata[7];
                default:  ;
            endcase
        end

        case (r_q.state)
            ST_IDLE: begin
                flush_now = flush_req;
                if (req_valid) begin
                    r_d.held_addr = req_addr;
                    if (!in_range || !dir_present) begin
                        r_d.rsp_valid = 1'b1;
                        r_d.rsp_fault = 1'b1;
                        r_d.rsp_addr  = '0;
                    end else if (hit) begin
                        r_d.rsp_valid = 1'b1;
                        r_d.rsp_fault = 1'b0;
                        r_d.rsp_addr  = {hit_frame, req_addr[PAGE_SH-1:0]};
                    end else begin
                        r_d.state        = ST_WAIT;
                        r_d.mem_rd_valid = 1'b1;
                        r_d.mem_rd_addr  = {dir_frame, req_addr[SPAN_SH-1:PAGE_SH], 2'b00};
                        r_d.flush_pend   = 1'b0;
                    end
                end
            end
            ST_WAIT: begin
                if (flush_req) r_d.flush_pend = 1'b1;
                if (mem_rsp_valid) begin
                    r_d.state     = ST_IDLE;
                    r_d.rsp_valid = 1'b1;
                    r_d.rsp_fault = !mem_rsp_data[0];
                    r_d.rsp_addr  = mem_rsp_data[0] ?
                        {mem_rsp_data[ADDR_W-1:PAGE_SH], r_q.held_addr[PAGE_SH-1:0]} : '0;
                    r_d.flush_pend = 1'b0;
                    if (r_q.flush_pend || flush_req) flush_now = 1'b1;
                    else ins_en = mem_rsp_data[0];
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready    = (r_q.state == ST_IDLE);
    assign rsp_valid    = r_q.rsp_valid;
    assign rsp_fault    = r_q.rsp_fault;
    assign rsp_addr     = r_q.rsp_addr;
    assign mem_rd_valid = r_q.mem_rd_valid;
    assign mem_rd_addr  = r_q.mem_rd_addr;

    // R12
    accept_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid || mem_rd_valid));

    // R12
    single_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready);

    // R5
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_addr == '0));

    // R4
    fetch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && mem_rsp_valid) |=> (rsp_valid && req_ready));

    // R4
    read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !mem_rd_valid);

endmodule

// File: tb/aper_xlate_test.sv
module aper_xlate_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, rsp_valid, rsp_fault, mem_rd_valid;
    logic [31:0] rsp_addr, mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    bit          m_pres [64];
    logic [19:0] m_dfr  [64];
    logic [9:0]  m_base = '0;
    logic [7:0]  m_size = '0;
    bit          m_on = 1'b0;
    bit          c_val [4];
    logic [19:0] c_tag [4];
    logic [19:0] c_dat [4];
    int          c_ptr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aper_xlate uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        return {a[21:2] ^ 20'h5A3C1, 11'h0, (a[4:2] != 3'd5)};
    endfunction

    task automatic model_flush();
        for (int i = 0; i < 4; i++) c_val[i] = 1'b0;
        c_ptr = 0;
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            2'd0: begin m_pres[data[5:0]] = data[8]; m_dfr[data[5:0]] = data[31:12]; end
            2'd1: m_base = data[31:22];
            2'd2: m_size = data[7:0];
            default: begin
                if (data[7] && !m_on) model_flush();
                m_on = data[7];
            end
        endcase
    endtask

    task automatic dir_word(input int idx, input bit pres);
        cfg(2'd0, {20'h10000 + 20'(idx * 17), 3'b000, pres, 2'b00, 6'(idx)});
    endtask

    task automatic xlate(input logic [31:0] a, input int lat, input bit midflush);
        logic [9:0]  rel;
        int          lim;
        bit          e_fault, e_mem;
        logic [31:0] e_addr, maddr, mdata;
        string       tag;
        int          hit_way;
        rel = a[31:22] - m_base;
        lim = 64 >> $countones(m_size[5:3]);
        e_fault = 1'b0; e_mem = 1'b0; e_addr = '0; maddr = '0; mdata = '0; hit_way = -1;
        if (int'(rel) >= lim) begin
            e_fault = 1'b1; tag = "R6";
        end else if (!m_pres[rel[5:0]]) begin
            e_fault = 1'b1; tag = "R7";
        end else begin
            for (int i = 0; i < 4; i++) if (c_val[i] && c_tag[i] == a[31:12]) hit_way = i;
            if (hit_way >= 0) begin
                e_addr = {c_dat[hit_way], a[11:0]}; tag = "R8";
            end else begin
                e_mem = 1'b1;
                maddr = {m_dfr[rel[5:0]], a[21:12], 2'b00};
                mdata = mem_fn(maddr);
                if (mdata[0]) begin e_addr = {mdata[31:12], a[11:0]}; tag = "R4"; end
                else begin e_fault = 1'b1; tag = "R5"; end
            end
        end
        @(negedge clk);
        check(req_ready == 1'b1, "R12 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_rd_valid == e_mem, {tag, " memory read strobe"}, 32'(mem_rd_valid), 32'(e_mem));
        if (e_mem) begin
            check(mem_rd_addr == maddr, "R3 entry read address", mem_rd_addr, maddr);
            for (int i = 0; i < lat; i++) begin
                if (midflush && i < 2) begin
                    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = (i == 0) ? 32'h2200 : 32'h2280;
                end else begin
                    cfg_we = 1'b0;
                end
                check(req_ready == 1'b0 && rsp_valid == 1'b0, "R12 busy while fetching",
                      32'(req_ready), 32'd0);
                @(negedge clk);
            end
            cfg_we = 1'b0;
            mem_rsp_valid = 1'b1; mem_rsp_data = mdata;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (midflush) begin
                model_flush(); m_on = 1'b1;   // R11: no insert
            end else if (mdata[0]) begin
                c_val[c_ptr] = 1'b1; c_tag[c_ptr] = a[31:12]; c_dat[c_ptr] = mdata[31:12];
                c_ptr = (c_ptr + 1) % 4;
            end
        end
        check(rsp_valid == 1'b1, {tag, " response strobe"}, 32'(rsp_valid), 32'd1);
        check(rsp_fault == e_fault, {tag, " fault flag"}, 32'(rsp_fault), 32'(e_fault));
        check(rsp_addr == e_addr, {tag, " translated address"}, rsp_addr, e_addr);
    endtask

    function automatic logic [31:0] page_addr(input int rel, input int ent, input int off);
        return 32'h4000_0000 + (32'(rel) << 22) + (32'(ent) << 12) + 32'(off);
    endfunction

    initial begin
        logic [7:0] codes [4];
        void'($urandom(32'd1234));
        codes[0] = 8'd0; codes[1] = 8'd32; codes[2] = 8'd48; codes[3] = 8'd56;
        for (int i = 0; i < 64; i++) begin m_pres[i] = 1'b0; m_dfr[i] = '0; end
        model_flush();

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'd0);
        check(mem_rd_valid == 1'b0, "R1 no read after reset", 32'(mem_rd_valid), 32'd0);

        cfg(2'd3, 32'h2280);
        cfg(2'd1, 32'h4000_0000);
        cfg(2'd2, 32'd0);
        // R1: directory empty, so a request faults
        xlate(page_addr(0, 1, 0), 1, 1'b0);
        for (int i = 0; i < 64; i++) dir_word(i, 1'b1);

        // R4 miss then R8 hit on the same page
        xlate(page_addr(0, 1, 12'h234), 2, 1'b0);
        xlate(page_addr(0, 1, 12'hfff), 1, 1'b0);
        // R5 unmapped second-level entry (entry index low bits 5)
        xlate(page_addr(0, 5, 12'habc), 1, 1'b0);
        // R2 clearing the present bit invalidates an entry (fault path R7)
        dir_word(3, 1'b0);
        xlate(page_addr(3, 2, 0), 1, 1'b0);
        dir_word(3, 1'b1);
        xlate(page_addr(3, 2, 0), 3, 1'b0);
        // R6 size limit boundary with 32 MB, and below-base wrap
        cfg(2'd2, 32'd56);
        xlate(page_addr(7, 4, 8), 1, 1'b0);
        xlate(page_addr(8, 4, 8), 1, 1'b0);
        xlate(32'h3FF0_0000, 1, 1'b0);
        cfg(2'd2, 32'd0);
        xlate(page_addr(63, 0, 4), 1, 1'b0);

        // R9 round-robin eviction
        cfg(2'd3, 32'h2200); cfg(2'd3, 32'h2280);
        for (int p = 0; p < 5; p++) xlate(page_addr(p, 0, 16), 1, 1'b0);
        xlate(page_addr(0, 0, 32), 1, 1'b0);
        xlate(page_addr(2, 0, 48), 1, 1'b0);
        // R10 repeated enable write keeps the cache, toggle empties it
        cfg(2'd3, 32'h2280);
        xlate(page_addr(2, 0, 52), 1, 1'b0);
        cfg(2'd3, 32'h2200); cfg(2'd3, 32'h2280);
        xlate(page_addr(2, 0, 56), 1, 1'b0);
        // R11 flush during fetch: result returned, not cached, older pages gone
        xlate(page_addr(4, 0, 60), 3, 1'b1);
        xlate(page_addr(4, 0, 64), 1, 1'b0);
        xlate(page_addr(2, 0, 68), 1, 1'b0);

        for (int n = 0; n < 400; n++) begin
            int r = $urandom % 40;
            if (r == 0) begin
                cfg(2'd3, 32'h2200); cfg(2'd3, 32'h2280);
            end else if (r == 1) begin
                cfg(2'd2, 32'(codes[$urandom % 4]));
            end else if (r == 2) begin
                dir_word($urandom % 64, 1'($urandom % 2));
            end else begin
                int lat = 1 + ($urandom % 3);
                bit mf = (lat >= 2) && (($urandom % 10) == 0);
                xlate(page_addr($urandom % 70, $urandom % 8, $urandom % 4096), lat, mf);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule